// File: doc/BRIEF.md
# Byte-Wide Crossbar Switch Fabric

This block joins a set of byte-wide source ports to a set of byte-wide sink ports through a crossbar that runs on the system clock. A source sets up its own route in-band: the first byte of a new transfer is a port code naming the sink it wants, and three padding bytes follow. Once the route exists, every later byte from that source reaches the chosen sink unchanged and in order. The route stays up until the sink pulses its done line. After that the source is free again, and the next byte it sends is read as a new port code.

Sources move data in groups of four bytes and look at their hold line only between groups. A small buffer on each source absorbs a group that is already in flight, so sink back-pressure never drops a byte. When several sources ask for the same free sink, a round-robin arbiter grants it to one of them. The others stay on hold until the sink finishes with the winner.

Top module: `xbar_fabric`

## Requirements
- R1: While reset is high and in the cycle after it, every out_we and every in_hold is low, and no route exists.
- R2: The first byte of a transfer is a port code, and codes 0 to N_OUT-1 select sink 0 to N_OUT-1. That byte and the three bytes after it are never forwarded, whatever the three bytes hold, including values that are valid port codes.
- R3: Once routed, each byte a source writes appears on its sink's out_data exactly once, in write order and unchanged. When the sink is not full, it appears in the cycle after the write.
- R4: A routed source sees in_hold high while it does not yet own its sink, or while its buffer holds more than FIFO_DEPTH-4 bytes (more than 4 with defaults). A source starts a four-byte group only while in_hold is low.
- R5: When several sources wait for the same free sink, it goes to the first waiting source in cyclic index order after the source it last served. Before any grant, source 0 comes first. The sources that lose keep in_hold high.
- R6: out_we of a sink is never high while its out_full is high.
- R7: A first byte of N_OUT or above is dropped together with its three following bytes. Nothing reaches any sink, in_hold stays low, and the next byte is again read as a port code.
- R8: A done pulse on a sink ends only the route that sink holds, and the source's next byte is a port code. A done pulse on a sink with no route has no effect.
- R9: A source holds at most one route at a time. Different sources can stream to different sinks in the same cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| in_we | input | N_IN | Per-source byte strobe |
| in_data | input | N_IN*8 | Per-source byte |
| in_hold | output | N_IN | Per-source hold, read by the source between four-byte groups |
| out_we | output | N_OUT | Per-sink byte strobe |
| out_data | output | N_OUT*8 | Per-sink byte |
| out_full | input | N_OUT | Per-sink back-pressure |
| out_done | input | N_OUT | Per-sink pulse that ends the route |

## Verification
A wrong route-setup state shows within one byte. A padding byte leaks onto a sink, or a payload byte goes to the wrong sink, and the per-sink expected-byte queues catch it in the cycle after the write. A wrong owner or pointer in an arbiter shows at the next contention: the bench predicts the winner from its own record of past grants and compares in_hold across the waiting sources. A wrong buffer count shows when a held sink is released and a byte goes missing or arrives twice, or when in_hold does not rise after the second group written against a full sink.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
    localparam int BYTE_W    = 8;
    localparam int BURST_LEN = 4;
    localparam int PAD_LEN   = BURST_LEN - 1;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        logic  vld;
        byte_t data;
    } beat_t;

    typedef enum logic [1:0] {
        ING_ADDR,
        ING_PAD,
        ING_DROP,
        ING_LINK
    } ing_state_e;

    function automatic int idx_w(int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    function automatic logic code_hits_port(byte_t code, int n_out);
        return int'(code) < n_out;
    endfunction
endpackage

// File: rtl/xbar_byte_fifo.sv
module xbar_byte_fifo
    import xbar_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW = idx_w(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  byte_t         wdata,
    input  logic          pop,
    output beat_t         head,
    output logic [CW-1:0] fill
);
    byte_t           mem [DEPTH];
    logic [AW-1:0]   wr_ptr;
    logic [AW-1:0]   rd_ptr;
    logic            do_push;
    logic            do_pop;

    function automatic logic [AW-1:0] ptr_next(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign do_push = push && (fill != CW'(DEPTH));
    assign do_pop  = pop && (fill != '0);

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (do_push) wr_ptr <= ptr_next(wr_ptr);
            if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
            fill <= fill + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wr_ptr] <= wdata;
    end

    always_comb begin
        head.vld  = (fill != '0);
        head.data = mem[rd_ptr];
    end
endmodule

// File: rtl/xbar_ingress.sv
module xbar_ingress
    import xbar_pkg::*;
#(
    parameter int N_OUT = 4,
    parameter int DEPTH = 8,
    localparam int OW = idx_w(N_OUT),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_we,
    input  byte_t         in_data,
    output logic          in_hold,
    input  logic          granted,
    input  logic          release_link,
    input  logic          pop,
    output logic [OW-1:0] tgt,
    output logic          req,
    output beat_t         head
);
    ing_state_e    st;
    logic [1:0]    pad_cnt;
    logic [CW-1:0] fill;
    logic          push;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ING_ADDR;
            pad_cnt <= '0;
            tgt     <= '0;
        end else if (release_link) begin
            st      <= ING_ADDR;
            pad_cnt <= '0;
        end else begin
            unique case (st)
                ING_ADDR: if (in_we) begin
                    pad_cnt <= '0;
                    if (code_hits_port(in_data, N_OUT)) begin
                        tgt <= in_data[OW-1:0];
                        st  <= ING_PAD;
                    end else begin
                        st  <= ING_DROP;
                    end
                end
                ING_PAD, ING_DROP: if (in_we) begin
                    pad_cnt <= pad_cnt + 1'b1;
                    if (pad_cnt == 2'(PAD_LEN - 1))
                        st <= (st == ING_PAD) ? ING_LINK : ING_ADDR;
                end
                ING_LINK: st <= ING_LINK;
                default:  st <= ING_ADDR;
            endcase
        end
    end

    assign push    = (st == ING_LINK) && in_we && !release_link;
    assign req     = (st == ING_PAD) || (st == ING_LINK);
    assign in_hold = (st == ING_LINK) &&
                     (!granted || (fill > CW'(DEPTH - BURST_LEN)));

    xbar_byte_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .flush (release_link),
        .push  (push),
        .wdata (in_data),
        .pop   (pop),
        .head  (head),
        .fill  (fill)
    );
endmodule

// File: rtl/xbar_out_port.sv
module xbar_out_port
    import xbar_pkg::*;
#(
    parameter int N_IN = 4,
    localparam int IW = idx_w(N_IN)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_IN-1:0] req,
    input  logic            done,
    output logic            own_valid,
    output logic [IW-1:0]   own_idx
);
    logic [IW-1:0] ptr;
    logic [IW-1:0] pick;
    logic          found;
    int            cand;

    always_comb begin
        found = 1'b0;
        pick  = ptr;
        cand  = 0;
        for (int k = 0; k < N_IN; k++) begin
            cand = int'(ptr) + k;
            if (cand >= N_IN) cand = cand - N_IN;
            if (!found && req[cand]) begin
                found = 1'b1;
                pick  = IW'(cand);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            own_valid <= 1'b0;
            own_idx   <= '0;
            ptr       <= '0;
        end else if (own_valid) begin
            if (done) own_valid <= 1'b0;
        end else if (found) begin
            own_valid <= 1'b1;
            own_idx   <= pick;
            ptr       <= (pick == IW'(N_IN - 1)) ? '0 : pick + 1'b1;
        end
    end
endmodule

// File: rtl/xbar_fabric.sv
module xbar_fabric
    import xbar_pkg::*;
#(
    parameter int N_IN       = 4,
    parameter int N_OUT      = 4,
    parameter int FIFO_DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [N_IN-1:0]              in_we,
    input  logic [N_IN-1:0][BYTE_W-1:0]  in_data,
    output logic [N_IN-1:0]              in_hold,
    output logic [N_OUT-1:0]             out_we,
    output logic [N_OUT-1:0][BYTE_W-1:0] out_data,
    input  logic [N_OUT-1:0]             out_full,
    input  logic [N_OUT-1:0]             out_done
);
    localparam int IW = idx_w(N_IN);
    localparam int OW = idx_w(N_OUT);

    logic [N_IN-1:0][OW-1:0]  tgt;
    logic [N_IN-1:0]          req;
    logic [N_IN-1:0]          granted;
    logic [N_IN-1:0]          release_link;
    logic [N_IN-1:0]          pop;
    beat_t [N_IN-1:0]         head;
    logic [N_OUT-1:0][N_IN-1:0] req_m;
    logic [N_OUT-1:0]         own_valid;
    logic [N_OUT-1:0][IW-1:0] own_idx;

    for (genvar gi = 0; gi < N_IN; gi++) begin : g_in
        xbar_ingress #(.N_OUT(N_OUT), .DEPTH(FIFO_DEPTH)) u_ing (
            .clk          (clk),
            .rst          (rst),
            .in_we        (in_we[gi]),
            .in_data      (in_data[gi]),
            .in_hold      (in_hold[gi]),
            .granted      (granted[gi]),
            .release_link (release_link[gi]),
            .pop          (pop[gi]),
            .tgt          (tgt[gi]),
            .req          (req[gi]),
            .head         (head[gi])
        );
    end

    for (genvar go = 0; go < N_OUT; go++) begin : g_out
        xbar_out_port #(.N_IN(N_IN)) u_port (
            .clk       (clk),
            .rst       (rst),
            .req       (req_m[go]),
            .done      (out_done[go]),
            .own_valid (own_valid[go]),
            .own_idx   (own_idx[go])
        );
    end

    always_comb begin
        for (int j = 0; j < N_OUT; j++)
            for (int i = 0; i < N_IN; i++)
                req_m[j][i] = req[i] && (tgt[i] == OW'(j));
    end

    always_comb begin
        for (int i = 0; i < N_IN; i++) begin
            granted[i]      = own_valid[tgt[i]] && (own_idx[tgt[i]] == IW'(i));
            release_link[i] = granted[i] && out_done[tgt[i]];
            pop[i]          = granted[i] && head[i].vld && !out_full[tgt[i]];
        end
    end

    always_comb begin
        for (int j = 0; j < N_OUT; j++) begin
            out_we[j]   = own_valid[j] && head[own_idx[j]].vld && !out_full[j];
            out_data[j] = head[own_idx[j]].data;
        end
    end
endmodule

// File: rtl/xbar_fabric_chk.sv
module xbar_fabric_chk
    import xbar_pkg::*;
#(
    parameter int N_IN  = 4,
    parameter int N_OUT = 4,
    localparam int IW = idx_w(N_IN)
) (
    input logic                     clk,
    input logic                     rst,
    input logic [N_OUT-1:0]         out_we,
    input logic [N_OUT-1:0]         out_full,
    input logic [N_OUT-1:0]         out_done,
    input logic [N_IN-1:0]          in_hold,
    input logic [N_OUT-1:0]         own_valid,
    input logic [N_OUT-1:0][IW-1:0] own_idx
);
    logic [N_IN-1:0][N_OUT-1:0] owned_by;

    always_comb begin
        for (int i = 0; i < N_IN; i++)
            for (int j = 0; j < N_OUT; j++)
                owned_by[i][j] = own_valid[j] && (own_idx[j] == IW'(i));
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (out_we == '0) && (in_hold == '0) && (own_valid == '0)); // R1

    for (genvar j = 0; j < N_OUT; j++) begin : g_port
        AST_WE_BLOCKED_BY_FULL: assert property (@(posedge clk) disable iff (rst)
            out_full[j] |-> !out_we[j]); // R6
        AST_WE_NEEDS_ROUTE: assert property (@(posedge clk) disable iff (rst)
            out_we[j] |-> own_valid[j]); // R3
        AST_ROUTE_HELD: assert property (@(posedge clk) disable iff (rst)
            (own_valid[j] && !out_done[j]) |=> (own_valid[j] && $stable(own_idx[j]))); // R8
        AST_DONE_FREES: assert property (@(posedge clk) disable iff (rst)
            (own_valid[j] && out_done[j]) |=> !own_valid[j]); // R8
    end

    for (genvar i = 0; i < N_IN; i++) begin : g_src
        AST_SINGLE_ROUTE: assert property (@(posedge clk) disable iff (rst)
            $countones(owned_by[i]) <= 1); // R9
    end
endmodule

bind xbar_fabric xbar_fabric_chk #(.N_IN(N_IN), .N_OUT(N_OUT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .out_we    (out_we),
    .out_full  (out_full),
    .out_done  (out_done),
    .in_hold   (in_hold),
    .own_valid (own_valid),
    .own_idx   (own_idx)
);

// File: tb/xbar_fabric_tb.sv
module xbar_fabric_tb;
    import xbar_pkg::*;

    localparam int N_IN  = 4;
    localparam int N_OUT = 4;

    logic                         clk = 1'b0;
    logic                         rst = 1'b1;
    logic [N_IN-1:0]              in_we = '0;
    logic [N_IN-1:0][BYTE_W-1:0]  in_data = '0;
    logic [N_IN-1:0]              in_hold;
    logic [N_OUT-1:0]             out_we;
    logic [N_OUT-1:0][BYTE_W-1:0] out_data;
    logic [N_OUT-1:0]             out_full = '0;
    logic [N_OUT-1:0]             out_done = '0;

    int    vec = 0;
    int    err = 0;
    int    last_srv [N_OUT];
    byte_t exp_q [N_OUT][$];

    xbar_fabric #(.N_IN(N_IN), .N_OUT(N_OUT), .FIFO_DEPTH(8)) u_dut (
        .clk      (clk),
        .rst      (rst),
        .in_we    (in_we),
        .in_data  (in_data),
        .in_hold  (in_hold),
        .out_we   (out_we),
        .out_data (out_data),
        .out_full (out_full),
        .out_done (out_done)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        vec++;
        if (!ok) begin
            err++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    // R3 / R6 scoreboard, sampled away from the clock edges
    always @(negedge clk) begin
        #2;
        if (!rst) begin
            for (int j = 0; j < N_OUT; j++) begin
                if (out_full[j]) chk(!out_we[j], "R6 we while full", out_we[j], 0);
                if (out_we[j]) begin
                    if (exp_q[j].size() == 0) begin
                        chk(1'b0, "R3 unexpected byte", out_data[j], -1);
                    end else begin
                        byte_t e;
                        e = exp_q[j].pop_front();
                        chk(out_data[j] == e, "R3 payload byte", out_data[j], e);
                    end
                end
            end
        end
    end

    function automatic int rr_expect(input int j, input logic [N_IN-1:0] mask);
        for (int k = 1; k <= N_IN; k++) begin
            int c;
            c = (last_srv[j] + k) % N_IN;
            if (mask[c]) return c;
        end
        return -1;
    endfunction

    task automatic send4(input int i, input byte_t b0, input byte_t b1,
                         input byte_t b2, input byte_t b3);
        byte_t b [4];
        b[0] = b0; b[1] = b1; b[2] = b2; b[3] = b3;
        for (int m = 0; m < 4; m++) begin
            in_we[i]   = 1'b1;
            in_data[i] = b[m];
            @(negedge clk);
        end
        in_we[i] = 1'b0;
    endtask

    task automatic open_link(input int i, input byte_t code, input byte_t pad);
        while (in_hold[i]) @(negedge clk);
        send4(i, code, pad, pad, pad);
    endtask

    task automatic send_payload(input int i, input int j, input int seed, input int nb);
        for (int k = 0; k < nb; k++) begin
            byte_t b [4];
            while (in_hold[i]) @(negedge clk);
            for (int m = 0; m < 4; m++) begin
                b[m] = byte_t'(seed + 4 * k + m);
                exp_q[j].push_back(b[m]);
            end
            send4(i, b[0], b[1], b[2], b[3]);
        end
    endtask

    task automatic finish_link(input int j);
        while (exp_q[j].size() != 0) @(negedge clk);
        out_done[j] = 1'b1;
        @(negedge clk);
        out_done[j] = 1'b0;
    endtask

    task automatic transfer(input int i, input int j, input int seed, input int nb,
                            input byte_t pad);
        open_link(i, byte_t'(j), pad);
        send_payload(i, j, seed, nb);
        finish_link(j);
        last_srv[j] = i;
    endtask

    task automatic contend(input logic [N_IN-1:0] mask, input int j, input int seed);
        logic [N_IN-1:0] left;
        left = mask;
        for (int i = 0; i < N_IN; i++) begin
            if (mask[i]) begin
                fork
                    automatic int ii = i;
                    open_link(ii, byte_t'(j), 8'h00);
                join_none
            end
        end
        wait fork;
        while (left != '0) begin
            int w;
            repeat (2) @(negedge clk);
            #1;
            w = rr_expect(j, left);
            for (int i = 0; i < N_IN; i++)
                if (left[i])
                    chk(in_hold[i] == (i != w), "R5 round-robin hold", in_hold[i], int'(i != w));
            send_payload(w, j, seed + 32 * w, 1);
            finish_link(j);
            last_srv[j] = w;
            left[w] = 1'b0;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", vec, err);
        $finish;
    end

    initial begin
        for (int j = 0; j < N_OUT; j++) last_srv[j] = N_IN - 1;

        // R1: reset state
        repeat (3) @(negedge clk);
        #1;
        chk(out_we == '0, "R1 out_we in reset", out_we, 0);
        chk(in_hold == '0, "R1 in_hold in reset", in_hold, 0);
        rst = 1'b0;
        @(negedge clk);
        #1;
        chk(out_we == '0, "R1 out_we after reset", out_we, 0);
        chk(in_hold == '0, "R1 in_hold after reset", in_hold, 0);

        // R2 R3 R8: every source to every sink, odd sources with code-like pads
        for (int i = 0; i < N_IN; i++)
            for (int j = 0; j < N_OUT; j++)
                transfer(i, j, 16 * i + 4 * j, 1 + (i + j) % 2,
                         (i % 2 == 1) ? 8'h02 : 8'h00);

        // R7: out-of-range codes dropped with their pads
        open_link(0, 8'h04, 8'h01);
        repeat (3) @(negedge clk);
        #1;
        chk(in_hold[0] == 1'b0, "R7 hold after drop N_OUT", in_hold[0], 0);
        chk(out_we == '0, "R7 no sink activity", out_we, 0);
        open_link(0, 8'hF0, 8'h03);
        repeat (3) @(negedge clk);
        #1;
        chk(in_hold[0] == 1'b0, "R7 hold after drop F0", in_hold[0], 0);
        transfer(0, 2, 8'h70, 2, 8'h00);

        // R4 R6: buffer fill against a full sink
        out_full[2] = 1'b1;
        open_link(1, 8'd2, 8'h00);
        send_payload(1, 2, 8'h90, 1);
        #1;
        chk(in_hold[1] == 1'b0, "R4 hold after one group", in_hold[1], 0);
        send_payload(1, 2, 8'hA0, 1);
        #1;
        chk(in_hold[1] == 1'b1, "R4 hold after two groups", in_hold[1], 1);
        repeat (5) @(negedge clk);
        #1;
        chk(out_we[2] == 1'b0, "R6 sink stalled", out_we[2], 0);
        out_full[2] = 1'b0;
        finish_link(2);
        last_srv[2] = 1;

        // R5: contention, pairs and all sources
        contend(4'b1001, 1, 8'h10);
        contend(4'b0110, 1, 8'h40);
        contend(4'b1111, 3, 8'h80);

        // R9 R8: parallel routes, stray done on an idle sink
        fork
            transfer(0, 2, 8'hC0, 3, 8'h00);
            transfer(1, 3, 8'hD0, 3, 8'h00);
            begin
                repeat (6) @(negedge clk);
                out_done[0] = 1'b1;
                @(negedge clk);
                out_done[0] = 1'b0;
            end
        join

        // R8: stray done mid-route leaves the route intact
        open_link(3, 8'd0, 8'h00);
        out_full[0] = 1'b1;
        send_payload(3, 0, 8'h20, 1);
        out_done[1] = 1'b1;
        @(negedge clk);
        out_done[1] = 1'b0;
        out_full[0] = 1'b0;
        send_payload(3, 0, 8'h24, 1);
        finish_link(0);
        last_srv[0] = 3;

        repeat (4) @(negedge clk);
        for (int j = 0; j < N_OUT; j++)
            chk(exp_q[j].size() == 0, "R3 all bytes delivered", exp_q[j].size(), 0);
        chk(out_we == '0, "R8 quiet after teardown", out_we, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vec, err);
        $finish;
    end
endmodule